// File: doc/BRIEF.md
# Power-controller interrupt packet dispatcher

This block sits behind the transaction sequencer that talks to a power-management controller. It accepts one unsolicited packet at a time. A packet is a status byte followed by payload bytes. The sequencer first announces the total length with a start strobe, then delivers the bytes as valid-qualified beats, with idle cycles allowed between them. The block reads the status byte and the length, then routes the packet to one of four places:

- the request that is parked waiting for a bus reply;
- an input-event byte stream for keyboard and pointer data;
- the backlight and volume logic;
- a saturating count of packets nobody handles.

A button packet updates the volume and turns a brightness level into an 8-bit brightness code. When the backlight is enabled, the block then raises follow-up command requests toward the sequencer: a brightness command carrying the code, and a power command carrying an on/off decision. Each kind of command is held off until the sequencer reports that the previous command of the same kind has completed. All outputs are registered, so every effect of a beat appears one clock after that beat is taken. Command requests appear one clock after that.

Top module: `pwr_irq_dispatch`

## Requirements
- R1: A start strobe with length 0 produces a one-cycle `attn_clear` pulse in the next cycle. No byte is consumed and no other output reacts.
- R2: A status byte with bit 4 set and bit 2 clear marks a bus reply, provided `parked_valid` is high when the status beat is taken. For a total length above 2, payload bytes 1..len-1 appear in order on `rpl_valid`/`rpl_data`. `rpl_done` pulses one cycle after the final beat, with `rpl_len` = len-1.
- R3: A bus reply whose total length is 1 or 2 forwards no byte on `rpl_valid`. It completes with `rpl_done` and `rpl_len` = 0.
- R4: A bus reply that arrives while `parked_valid` is low at its status beat pulses `extra_reply` once. It is then dropped: no reply output, and the unhandled count does not change.
- R5: A status byte with both bit 4 and bit 2 set forwards every payload byte, in order, on `evt_valid`/`evt_data`. `evt_last` is set on the final byte.
- R6: A status byte of exactly 0x08 with total length 3 is a button packet. `volume` takes payload byte 2. The brightness level is payload byte 1 shifted right by 3.
- R7: The brightness code is 0x7F for level 0, and 0x4A minus twice the level otherwise. It appears on `brt_code` with a one-cycle `brt_req`, two cycles after the final button beat.
- R8: In that same cycle, `pwr_req` pulses with `pwr_on` = 1 when the code is below 0x7F and 0 otherwise. Neither request is raised when `backlight_en` is low; the volume still updates.
- R9: After a `brt_req`, no further `brt_req` is raised until `brt_done` has been seen. The same holds for `pwr_req` and `pwr_done`. A button packet that finds a command outstanding raises no request of that kind.
- R10: A status byte of 0x80 with total length 1 is ignored with no output at all. In particular, `unhandled_cnt` is unchanged.
- R11: Any other non-empty packet increments `unhandled_cnt` by one. This includes 0x08 with length other than 3 and 0x80 with length other than 1. The count saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Packet announce strobe, only while no packet is in progress |
| pkt_len | input | LEN_W | Total packet length in bytes, status byte included |
| beat_valid | input | 1 | A packet byte is present on `beat_data` |
| beat_data | input | 8 | Packet byte, status byte first |
| parked_valid | input | 1 | A reply-expecting request is waiting |
| backlight_en | input | 1 | Backlight enabled; allows command requests |
| brt_done | input | 1 | Previous brightness command completed |
| pwr_done | input | 1 | Previous power command completed |
| attn_clear | output | 1 | Empty packet seen; clear attention pending |
| rpl_valid | output | 1 | Reply payload byte valid |
| rpl_data | output | 8 | Reply payload byte |
| rpl_done | output | 1 | Parked request completed |
| rpl_len | output | LEN_W | Reply payload length, valid with `rpl_done` |
| extra_reply | output | 1 | Bus reply arrived with nothing parked |
| evt_valid | output | 1 | Input-event byte valid |
| evt_data | output | 8 | Input-event byte |
| evt_last | output | 1 | Final input-event byte of the packet |
| brt_req | output | 1 | Brightness command request |
| brt_code | output | 8 | Brightness code, valid with `brt_req` |
| pwr_req | output | 1 | Backlight power command request |
| pwr_on | output | 1 | Power command argument, valid with `pwr_req` |
| volume | output | 8 | Last volume value from a button packet |
| unhandled_cnt | output | CNT_W | Saturating count of unhandled packets |

## Verification
A misrouted status byte shows up within one cycle of that byte. It appears as a reply, event, error or count pulse on the wrong port, and that cycle is compared against a bench model for every packet. A wrong byte index or length register shows up at the last beat: payload bytes are lost or shifted, `rpl_len` is off, or `evt_last` lands on the wrong byte. A stuck command-busy flag shows up only at the next button packet, as a request that is missing or duplicated. For that reason the stimulus interleaves completion strobes with button packets at random, with the backlight enabled and disabled.

// File: rtl/pdisp_pkg.sv
package pdisp_pkg;

    localparam logic [7:0] STS_BUS_EVT  = 8'h10;
    localparam logic [7:0] STS_AUTOPOLL = 8'h04;
    localparam logic [7:0] STS_BUTTON   = 8'h08;
    localparam logic [7:0] STS_TICK     = 8'h80;

    localparam logic [7:0] BRT_OFF_CODE = 8'h7F;
    localparam logic [7:0] BRT_TOP_CODE = 8'h4A;

    localparam int LVL_W = 5;

    typedef enum logic [2:0] {
        RT_REPLY,
        RT_EXTRA,
        RT_INPUT,
        RT_BUTTON,
        RT_TICK,
        RT_OTHER
    } route_e;

    typedef struct packed {
        logic             fire;
        logic [LVL_W-1:0] level;
    } btn_evt_t;

    function automatic route_e classify(input logic [7:0] sts,
                                        input logic       len_is_1,
                                        input logic       len_is_3,
                                        input logic       parked);
        if ((sts & STS_BUS_EVT) != 8'h00) begin
            if ((sts & STS_AUTOPOLL) != 8'h00) return RT_INPUT;
            if (parked)                        return RT_REPLY;
            return RT_EXTRA;
        end
        if (sts == STS_BUTTON && len_is_3) return RT_BUTTON;
        if (sts == STS_TICK && len_is_1)   return RT_TICK;
        return RT_OTHER;
    endfunction

    function automatic logic [7:0] level_to_code(input logic [LVL_W-1:0] lvl);
        if (lvl == '0) return BRT_OFF_CODE;
        return BRT_TOP_CODE - 8'({lvl, 1'b0});
    endfunction

endpackage

// File: rtl/pdisp_router.sv
module pdisp_router
    import pdisp_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_start,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             beat_valid,
    input  logic [7:0]       beat_data,
    input  logic             parked_valid,
    output logic             attn_clear,
    output logic             rpl_valid,
    output logic [7:0]       rpl_data,
    output logic             rpl_done,
    output logic [LEN_W-1:0] rpl_len,
    output logic             extra_reply,
    output logic             evt_valid,
    output logic [7:0]       evt_data,
    output logic             evt_last,
    output btn_evt_t         btn,
    output logic [7:0]       volume,
    output logic             unh_inc
);

    localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO   = LEN_W'(2);
    localparam logic [LEN_W-1:0] THREE = LEN_W'(3);

    typedef enum logic [1:0] {S_IDLE, S_HEAD, S_BODY} st_e;

    st_e              st;
    logic [LEN_W-1:0] len_r;
    logic [LEN_W-1:0] idx;
    route_e           route_r;
    route_e           head_route;
    logic             last_beat;
    logic             carry_payload;

    always_comb begin
        head_route    = classify(beat_data, len_r == ONE, len_r == THREE, parked_valid);
        last_beat     = (idx + ONE) == len_r;
        carry_payload = len_r > TWO;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            len_r       <= '0;
            idx         <= '0;
            route_r     <= RT_OTHER;
            attn_clear  <= 1'b0;
            rpl_valid   <= 1'b0;
            rpl_data    <= '0;
            rpl_done    <= 1'b0;
            rpl_len     <= '0;
            extra_reply <= 1'b0;
            evt_valid   <= 1'b0;
            evt_data    <= '0;
            evt_last    <= 1'b0;
            btn         <= '0;
            volume      <= '0;
            unh_inc     <= 1'b0;
        end else begin
            attn_clear  <= 1'b0;
            rpl_valid   <= 1'b0;
            rpl_done    <= 1'b0;
            extra_reply <= 1'b0;
            evt_valid   <= 1'b0;
            evt_last    <= 1'b0;
            btn.fire    <= 1'b0;
            unh_inc     <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (pkt_start) begin
                        if (pkt_len == '0) begin
                            attn_clear <= 1'b1;
                        end else begin
                            len_r <= pkt_len;
                            idx   <= ONE;
                            st    <= S_HEAD;
                        end
                    end
                end
                S_HEAD: begin
                    if (beat_valid) begin
                        route_r <= head_route;
                        case (head_route)
                            RT_EXTRA: extra_reply <= 1'b1;
                            RT_OTHER: unh_inc     <= 1'b1;
                            RT_REPLY: begin
                                if (len_r == ONE) begin
                                    rpl_done <= 1'b1;
                                    rpl_len  <= '0;
                                end
                            end
                            default: ;
                        endcase
                        st <= (len_r == ONE) ? S_IDLE : S_BODY;
                    end
                end
                S_BODY: begin
                    if (beat_valid) begin
                        idx <= idx + ONE;
                        case (route_r)
                            RT_REPLY: begin
                                if (carry_payload) begin
                                    rpl_valid <= 1'b1;
                                    rpl_data  <= beat_data;
                                end
                                if (last_beat) begin
                                    rpl_done <= 1'b1;
                                    rpl_len  <= carry_payload ? (len_r - ONE) : '0;
                                end
                            end
                            RT_INPUT: begin
                                evt_valid <= 1'b1;
                                evt_data  <= beat_data;
                                evt_last  <= last_beat;
                            end
                            RT_BUTTON: begin
                                if (idx == ONE) begin
                                    btn.level <= beat_data[7:3];
                                end else begin
                                    volume   <= beat_data;
                                    btn.fire <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                        if (last_beat) st <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pdisp_cmd_slot.sv
module pdisp_cmd_slot #(
    parameter int ARG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             allow,
    input  logic [ARG_W-1:0] arg_in,
    input  logic             done,
    output logic             req,
    output logic [ARG_W-1:0] arg_out
);

    logic busy;
    logic issue;

    assign issue = fire && allow && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= 1'b0;
            arg_out <= '0;
            busy    <= 1'b0;
        end else begin
            req  <= issue;
            busy <= issue || (busy && !done);
            if (issue) arg_out <= arg_in;
        end
    end

endmodule

// File: rtl/pdisp_sat_cnt.sv
module pdisp_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && cnt != TOP) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/pwr_irq_dispatch.sv
module pwr_irq_dispatch
    import pdisp_pkg::*;
#(
    parameter int LEN_W = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_start,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             beat_valid,
    input  logic [7:0]       beat_data,
    input  logic             parked_valid,
    input  logic             backlight_en,
    input  logic             brt_done,
    input  logic             pwr_done,
    output logic             attn_clear,
    output logic             rpl_valid,
    output logic [7:0]       rpl_data,
    output logic             rpl_done,
    output logic [LEN_W-1:0] rpl_len,
    output logic             extra_reply,
    output logic             evt_valid,
    output logic [7:0]       evt_data,
    output logic             evt_last,
    output logic             brt_req,
    output logic [7:0]       brt_code,
    output logic             pwr_req,
    output logic             pwr_on,
    output logic [7:0]       volume,
    output logic [CNT_W-1:0] unhandled_cnt
);

    btn_evt_t   btn;
    logic       unh_inc;
    logic [7:0] code_now;
    logic       on_now;

    pdisp_router #(.LEN_W(LEN_W)) u_router (
        .clk          (clk),
        .rst          (rst),
        .pkt_start    (pkt_start),
        .pkt_len      (pkt_len),
        .beat_valid   (beat_valid),
        .beat_data    (beat_data),
        .parked_valid (parked_valid),
        .attn_clear   (attn_clear),
        .rpl_valid    (rpl_valid),
        .rpl_data     (rpl_data),
        .rpl_done     (rpl_done),
        .rpl_len      (rpl_len),
        .extra_reply  (extra_reply),
        .evt_valid    (evt_valid),
        .evt_data     (evt_data),
        .evt_last     (evt_last),
        .btn          (btn),
        .volume       (volume),
        .unh_inc      (unh_inc)
    );

    always_comb begin
        code_now = level_to_code(btn.level);
        on_now   = code_now < BRT_OFF_CODE;
    end

    pdisp_cmd_slot #(.ARG_W(8)) u_brt_slot (
        .clk     (clk),
        .rst     (rst),
        .fire    (btn.fire),
        .allow   (backlight_en),
        .arg_in  (code_now),
        .done    (brt_done),
        .req     (brt_req),
        .arg_out (brt_code)
    );

    pdisp_cmd_slot #(.ARG_W(1)) u_pwr_slot (
        .clk     (clk),
        .rst     (rst),
        .fire    (btn.fire),
        .allow   (backlight_en),
        .arg_in  (on_now),
        .done    (pwr_done),
        .req     (pwr_req),
        .arg_out (pwr_on)
    );

    pdisp_sat_cnt #(.W(CNT_W)) u_unh_cnt (
        .clk (clk),
        .rst (rst),
        .inc (unh_inc),
        .cnt (unhandled_cnt)
    );

endmodule

// File: rtl/pwr_irq_dispatch_chk.sv
module pwr_irq_dispatch_chk #(
    parameter int LEN_W = 6,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             pkt_start,
    input logic [LEN_W-1:0] pkt_len,
    input logic             backlight_en,
    input logic             brt_done,
    input logic             pwr_done,
    input logic             attn_clear,
    input logic             rpl_valid,
    input logic             rpl_done,
    input logic [LEN_W-1:0] rpl_len,
    input logic             extra_reply,
    input logic             evt_valid,
    input logic             brt_req,
    input logic [7:0]       brt_code,
    input logic             pwr_req,
    input logic             pwr_on,
    input logic [CNT_W-1:0] unhandled_cnt
);

    logic brt_out;
    logic pwr_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            brt_out <= 1'b0;
            pwr_out <= 1'b0;
        end else begin
            brt_out <= brt_req || (brt_out && !brt_done);
            pwr_out <= pwr_req || (pwr_out && !pwr_done);
        end
    end

    assert_empty_pkt_R1: assert property (@(posedge clk) disable iff (rst)
        attn_clear |-> ($past(pkt_start) && $past(pkt_len) == '0));

    assert_short_reply_R3: assert property (@(posedge clk) disable iff (rst)
        rpl_done |-> rpl_len != LEN_W'(1));

    assert_extra_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        extra_reply |-> (!rpl_valid && !rpl_done));

    assert_streams_apart_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rpl_valid, evt_valid}));

    assert_code_range_R7: assert property (@(posedge clk) disable iff (rst)
        brt_req |-> (brt_code == 8'h7F || (brt_code <= 8'h4A && !brt_code[0])));

    assert_pwr_matches_R8: assert property (@(posedge clk) disable iff (rst)
        (brt_req && pwr_req) |-> (pwr_on == (brt_code != 8'h7F)));

    assert_gate_enable_R8: assert property (@(posedge clk) disable iff (rst)
        (brt_req || pwr_req) |-> $past(backlight_en));

    assert_brt_single_R9: assert property (@(posedge clk) disable iff (rst)
        brt_req |-> !brt_out);

    assert_pwr_single_R9: assert property (@(posedge clk) disable iff (rst)
        pwr_req |-> !pwr_out);

    assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (unhandled_cnt == $past(unhandled_cnt)
                  || unhandled_cnt == $past(unhandled_cnt) + CNT_W'(1)));

endmodule

bind pwr_irq_dispatch pwr_irq_dispatch_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .pkt_start     (pkt_start),
    .pkt_len       (pkt_len),
    .backlight_en  (backlight_en),
    .brt_done      (brt_done),
    .pwr_done      (pwr_done),
    .attn_clear    (attn_clear),
    .rpl_valid     (rpl_valid),
    .rpl_done      (rpl_done),
    .rpl_len       (rpl_len),
    .extra_reply   (extra_reply),
    .evt_valid     (evt_valid),
    .brt_req       (brt_req),
    .brt_code      (brt_code),
    .pwr_req       (pwr_req),
    .pwr_on        (pwr_on),
    .unhandled_cnt (unhandled_cnt)
);

// File: tb/pwr_irq_dispatch_test.sv
`timescale 1ns/1ps
module pwr_irq_dispatch_test;

    localparam int LEN_W = 6;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             pkt_start, beat_valid, parked_valid, backlight_en, brt_done, pwr_done;
    logic [LEN_W-1:0] pkt_len;
    logic [7:0]       beat_data;
    logic             attn_clear, rpl_valid, rpl_done, extra_reply, evt_valid, evt_last;
    logic [7:0]       rpl_data, evt_data, brt_code, volume;
    logic [LEN_W-1:0] rpl_len;
    logic             brt_req, pwr_req, pwr_on;
    logic [CNT_W-1:0] unhandled_cnt;

    always #2 clk = ~clk;

    pwr_irq_dispatch #(.LEN_W(LEN_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_len(pkt_len),
        .beat_valid(beat_valid), .beat_data(beat_data), .parked_valid(parked_valid),
        .backlight_en(backlight_en), .brt_done(brt_done), .pwr_done(pwr_done),
        .attn_clear(attn_clear), .rpl_valid(rpl_valid), .rpl_data(rpl_data),
        .rpl_done(rpl_done), .rpl_len(rpl_len), .extra_reply(extra_reply),
        .evt_valid(evt_valid), .evt_data(evt_data), .evt_last(evt_last),
        .brt_req(brt_req), .brt_code(brt_code), .pwr_req(pwr_req), .pwr_on(pwr_on),
        .volume(volume), .unhandled_cnt(unhandled_cnt)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // observed per packet
    int       m_attn, m_rpl_n, m_done, m_rlen, m_extra, m_evt_n, m_last_n, m_last_pos;
    int       m_brt, m_bcode, m_pwr, m_pon;
    logic [7:0] m_rpl [0:63];
    logic [7:0] m_evt [0:63];

    // stimulus and model state
    logic [7:0] pkt_b [0:63];
    int e_cnt = 0;
    int e_vol = 0;
    bit b_busy = 0;
    bit p_busy = 0;

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (attn_clear) m_attn++;
            if (rpl_valid && m_rpl_n < 64) begin m_rpl[m_rpl_n] = rpl_data; m_rpl_n++; end
            if (rpl_done) begin m_done++; m_rlen = int'(rpl_len); end
            if (extra_reply) m_extra++;
            if (evt_valid && m_evt_n < 64) begin
                m_evt[m_evt_n] = evt_data;
                if (evt_last) begin m_last_n++; m_last_pos = m_evt_n; end
                m_evt_n++;
            end
            if (brt_req) begin m_brt++; m_bcode = int'(brt_code); end
            if (pwr_req) begin m_pwr++; m_pon = int'(pwr_on); end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code_of(input int lvl);
        if (lvl < 1) return 8'h7F;
        return 8'h4A - 2 * lvl;
    endfunction

    task automatic clear_mon();
        m_attn = 0; m_rpl_n = 0; m_done = 0; m_rlen = -1; m_extra = 0;
        m_evt_n = 0; m_last_n = 0; m_last_pos = -1;
        m_brt = 0; m_bcode = -1; m_pwr = 0; m_pon = -1;
    endtask

    task automatic send_pkt(input int len, input bit gaps);
        @(negedge clk);
        clear_mon();
        pkt_start = 1'b1;
        pkt_len   = LEN_W'(len);
        @(negedge clk);
        pkt_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                beat_valid = 1'b0;
                @(negedge clk);
            end
            beat_valid = 1'b1;
            beat_data  = pkt_b[i];
            @(negedge clk);
        end
        beat_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // compute expectations for the packet just sent and compare
    task automatic verify(input int len);
        int e_attn = 0, e_rpl_n = 0, e_done = 0, e_rlen = -1, e_extra = 0;
        int e_evt_n = 0, e_last_n = 0, e_brt = 0, e_bcode = -1, e_pwr = 0, e_pon = -1;
        int first_bad;
        logic [7:0] sts;
        sts = pkt_b[0];
        if (len == 0) begin
            e_attn = 1;
        end else if (sts[4] && !sts[2]) begin
            if (parked_valid) begin
                e_done = 1;
                if (len > 2) begin e_rpl_n = len - 1; e_rlen = len - 1; end
                else e_rlen = 0;
            end else begin
                e_extra = 1;
            end
        end else if (sts[4] && sts[2]) begin
            e_evt_n = len - 1;
            e_last_n = (len > 1) ? 1 : 0;
        end else if (sts == 8'h08 && len == 3) begin
            e_vol = pkt_b[2];
            if (backlight_en) begin
                int code;
                code = code_of(int'(pkt_b[1] >> 3));
                if (!b_busy) begin e_brt = 1; e_bcode = code; b_busy = 1; end
                if (!p_busy) begin e_pwr = 1; e_pon = (code < 8'h7F) ? 1 : 0; p_busy = 1; end
            end
        end else if (sts == 8'h80 && len == 1) begin
            // ignored silently
        end else begin
            if (e_cnt < 255) e_cnt++;
        end

        chk(m_attn == e_attn, "R1 attn_clear pulses", m_attn, e_attn);
        chk(m_rpl_n == e_rpl_n, "R2 R3 reply byte count", m_rpl_n, e_rpl_n);
        first_bad = -1;
        for (int i = 0; i < e_rpl_n && i < m_rpl_n; i++)
            if (first_bad < 0 && m_rpl[i] !== pkt_b[i+1]) first_bad = i;
        chk(first_bad < 0, "R2 reply byte order (bad index)", first_bad, -1);
        chk(m_done == e_done && m_rlen == e_rlen, "R2 R3 reply completion length",
            m_rlen, e_rlen);
        chk(m_extra == e_extra, "R4 extra reply pulses", m_extra, e_extra);
        chk(m_evt_n == e_evt_n, "R5 event byte count", m_evt_n, e_evt_n);
        first_bad = -1;
        for (int i = 0; i < e_evt_n && i < m_evt_n; i++)
            if (first_bad < 0 && m_evt[i] !== pkt_b[i+1]) first_bad = i;
        chk(first_bad < 0, "R5 event byte order (bad index)", first_bad, -1);
        chk(m_last_n == e_last_n && (e_last_n == 0 || m_last_pos == e_evt_n - 1),
            "R5 evt_last position", m_last_pos, e_evt_n - 1);
        chk(int'(volume) == e_vol, "R6 volume", int'(volume), e_vol);
        chk(m_brt == e_brt && m_bcode == e_bcode, "R7 R9 brightness request code",
            m_bcode, e_bcode);
        chk(m_pwr == e_pwr && m_pon == e_pon, "R8 R9 power request on/off", m_pon, e_pon);
        chk(int'(unhandled_cnt) == e_cnt, "R10 R11 unhandled count",
            int'(unhandled_cnt), e_cnt);
    endtask

    task automatic run_pkt(input int len, input bit gaps);
        send_pkt(len, gaps);
        verify(len);
    endtask

    task automatic ack(input bit b, input bit p);
        @(negedge clk);
        brt_done = b;
        pwr_done = p;
        @(negedge clk);
        brt_done = 1'b0;
        pwr_done = 1'b0;
        if (b) b_busy = 0;
        if (p) p_busy = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; pkt_start = 0; pkt_len = '0; beat_valid = 0; beat_data = '0;
        parked_valid = 0; backlight_en = 0; brt_done = 0; pwr_done = 0;
        clear_mon();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!attn_clear && !rpl_valid && !rpl_done && !extra_reply && !evt_valid
            && !brt_req && !pwr_req, "R1 reset outputs idle", 0, 0);
        chk(volume == 8'h00 && unhandled_cnt == '0, "R11 reset count and volume",
            int'(unhandled_cnt), 0);

        // R1 empty packet
        run_pkt(0, 0);
        // R2 / R3 replies with a parked request
        parked_valid = 1;
        pkt_b[0] = 8'h10; pkt_b[1] = 8'hA1; pkt_b[2] = 8'hB2; pkt_b[3] = 8'hC3; pkt_b[4] = 8'hD4;
        run_pkt(5, 1);
        run_pkt(2, 0);
        run_pkt(1, 0);
        // R4 reply with nothing parked
        parked_valid = 0;
        run_pkt(4, 0);
        // R5 autopoll input
        pkt_b[0] = 8'h14;
        run_pkt(4, 1);
        // R6..R9 buttons
        backlight_en = 1;
        pkt_b[0] = 8'h08; pkt_b[1] = 8'h05; pkt_b[2] = 8'h33;
        run_pkt(3, 0);                              // level 0 -> 0x7F, off
        pkt_b[1] = 8'hFF; pkt_b[2] = 8'h44;
        run_pkt(3, 0);                              // R9 both busy: no requests
        ack(1, 0);
        run_pkt(3, 0);                              // level 31 -> 0x0C, power still busy
        ack(1, 1);
        pkt_b[1] = 8'h18; pkt_b[2] = 8'h55;
        run_pkt(3, 0);                              // level 3 -> 0x44, on
        ack(1, 1);
        backlight_en = 0;
        pkt_b[1] = 8'h40; pkt_b[2] = 8'h66;
        run_pkt(3, 0);                              // R8 disabled: volume only
        // R10 tick and R11 near-misses
        pkt_b[0] = 8'h80; run_pkt(1, 0);
        run_pkt(2, 0);
        pkt_b[0] = 8'h08; run_pkt(2, 0);
        pkt_b[0] = 8'h21; run_pkt(1, 0);

        // constrained random mix
        for (int n = 0; n < 800; n++) begin
            int kind;
            int len;
            kind = $urandom % 6;
            case (kind)
                0: pkt_b[0] = (8'($urandom) & 8'hEB) | 8'h10;
                1: pkt_b[0] = 8'($urandom) | 8'h14;
                2: pkt_b[0] = 8'h08;
                3: pkt_b[0] = 8'h80;
                4: pkt_b[0] = 8'($urandom) & 8'hEF;
                default: pkt_b[0] = 8'($urandom);
            endcase
            for (int i = 1; i < 8; i++) pkt_b[i] = 8'($urandom);
            len = ($urandom % 3 == 0) ? ((kind == 3) ? 1 : 3) : int'($urandom % 7);
            parked_valid = 1'($urandom);
            backlight_en = ($urandom % 4) != 0;
            run_pkt(len, 1);
            if ($urandom % 3 == 0) ack(1'($urandom), 1'($urandom));
        end

        // R11 saturation
        pkt_b[0] = 8'h01;
        for (int n = 0; n < 270; n++) begin
            send_pkt(1, 0);
            if (e_cnt < 255) e_cnt++;
        end
        chk(unhandled_cnt == 8'hFF, "R11 saturates at all ones", int'(unhandled_cnt), 255);
        run_pkt(1, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule